// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at the top of an error reporting hierarchy, in a root port. Each cycle it can accept one incoming error message, made of a severity code and a 16-bit requester source identifier. It keeps a root error status register with received flags for each error class, flags for repeated errors and a flag for the first fatal error. Beside it sits a 32-bit error source register. That register holds the identifier of the first correctable reporter in its low half and the first uncorrectable reporter in its high half.

Software reads both registers and clears reporting flags by writing ones. It writes the three-bit root command register to choose which error classes may raise an interrupt. The interrupt condition is the OR of every received flag whose class is enabled. With message-signalled interrupts on, the block emits a one-cycle pulse when that condition turns from false to true. With them off, a level interrupt output simply follows the condition. An interrupt message number is loaded into the top of the status register by a separate strobe.

Top module: `aer_root_collector`

## Requirements
- R1: After a synchronous active-low reset, root_status, err_source and root_cmd are all zero, msi_pulse and intx_out are low, and a message arriving before any command write raises no pulse.
- R2: A correctable message (msg_sev = 0) sets status bit 0. If bit 0 was already set, it sets bit 1 instead of capturing and leaves err_source[15:0] unchanged. Otherwise it writes msg_src into err_source[15:0].
- R3: A non-fatal message (msg_sev = 1) sets status bit 5 and status bit 2. If bit 2 was clear, it writes msg_src into err_source[31:16].
- R4: A fatal message (msg_sev = 2) sets status bit 6 and status bit 2. It also sets status bit 4 only when bit 2 was clear before the message.
- R5: A non-fatal or fatal message arriving while status bit 2 is set sets bit 3 and leaves err_source[31:16] unchanged.
- R6: A status write (sts_w1c) clears each of status bits 6..0 whose sts_wdata bit is one. It leaves bits written zero, the error source register and bits 31:27 unchanged.
- R7: When a status write and a message fall in the same cycle, the clear is applied first. The message then updates the cleared value, so its set bits survive and its first/multiple decisions see the cleared flags.
- R8: With msi_en high, a message raises msi_pulse for exactly one cycle, in the cycle after the message. It does so only if its class is enabled in root_cmd (bit 0 correctable, bit 1 non-fatal, bit 2 fatal) and the interrupt condition was false before.
- R9: With msi_en high, a command write (cmd_wr) raises a one-cycle msi_pulse only when it turns the interrupt condition from false to true. A write that leaves the condition true gives no pulse.
- R10: intx_out equals the interrupt condition (status bit 0 and cmd bit 0, or bit 5 and cmd bit 1, or bit 6 and cmd bit 2) while msi_en is low. It is low while msi_en is high, and msi_pulse never fires while msi_en is low.
- R11: Status bits 31:27 hold the interrupt message number loaded by vec_load from vec_num. No status write changes them.
- R12: A message with msg_sev = 3 changes no register and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 none |
| msg_src | input | 16 | Requester identifier of the reporter |
| cmd_wr | input | 1 | Write strobe for the root command register |
| cmd_wdata | input | 3 | New enables: bit 0 correctable, bit 1 non-fatal, bit 2 fatal |
| msi_en | input | 1 | Message-signalled interrupts are enabled |
| sts_w1c | input | 1 | Write-one-to-clear strobe for the status register |
| sts_wdata | input | 32 | Clear mask, only bits 6..0 act |
| vec_load | input | 1 | Load strobe for the interrupt message number |
| vec_num | input | 5 | Interrupt message number |
| root_status | output | 32 | Root error status register |
| err_source | output | 32 | Correctable source in 15:0, uncorrectable source in 31:16 |
| root_cmd | output | 3 | Root command register |
| msi_pulse | output | 1 | One-cycle message interrupt request |
| intx_out | output | 1 | Level interrupt while message interrupts are off |

## Verification
Message sequences cover first and repeated errors of each class, so that capture of the source can be told apart from setting the multiple flag. A fatal error arrives both after a non-fatal one and into a cleared register, which shows whether the first-fatal flag depends on prior uncorrectable history. Command writes are made with the condition false, then turning true, then staying true; these separate edge-triggered pulses from level behaviour, and the same sequences run with message interrupts off to exercise the level output. A clear and a message in the same cycle, a status write of all ones after a vector load, and the unused severity code each check that one update does not leak into the fields of another.

// File: rtl/aerc_pkg.sv
// Package: shared types and bit positions of the root error status collector.
// Assumes the status register is 32 bits wide, with reporting flags in the low
// bits and the interrupt message number in the top bits.
package aerc_pkg;

    localparam int STS_W    = 32;
    localparam int REPORT_W = 7;
    localparam int CMD_W    = 3;

    // Severity codes carried with each message
    typedef enum logic [1:0] {
        SEV_COR  = 2'd0,
        SEV_NF   = 2'd1,
        SEV_FAT  = 2'd2,
        SEV_NONE = 2'd3
    } sev_e;

    // Reporting flags, most significant first (bit 6 down to bit 0)
    typedef struct packed {
        logic fat;    // bit 6 fatal received
        logic nf;     // bit 5 non-fatal received
        logic ffat;   // bit 4 first uncorrectable was fatal
        logic munc;   // bit 3 multiple uncorrectable
        logic unc;    // bit 2 uncorrectable received
        logic mcor;   // bit 1 multiple correctable
        logic cor;    // bit 0 correctable received
    } rpt_t;

    // Command enables (bit 2 fatal, bit 1 non-fatal, bit 0 correctable)
    typedef struct packed {
        logic fat;
        logic nf;
        logic cor;
    } cmd_t;

    // Interrupt condition: any received class whose enable is set
    function automatic logic irq_cond(input rpt_t r, input cmd_t c);
        return (r.cor & c.cor) | (r.nf & c.nf) | (r.fat & c.fat);
    endfunction

endpackage

// File: rtl/aerc_msg_update.sv
// Module: computes the next reporting flags from the current flags, a
// write-one-to-clear mask and an incoming message, and says which half of the
// source register captures the requester identifier.
// Assumes: the clear is applied before the message, so a message in the same
// cycle as a clear sees the cleared flags and its own set bits survive.
module aerc_msg_update
    import aerc_pkg::*;
(
    input  rpt_t       rpt_cur,
    input  logic       clr_en,
    input  rpt_t       clr_mask,
    input  logic       msg_valid,
    input  logic [1:0] msg_sev,
    output rpt_t       rpt_next,
    output logic [1:0] cap_en      // [0] correctable half, [1] uncorrectable half
);

    rpt_t base;
    sev_e sev;

    assign sev = sev_e'(msg_sev);

    // Purpose: apply the software clear to form the base view
    always_comb begin
        base = rpt_cur;
        if (clr_en) begin
            base = rpt_cur & ~clr_mask;
        end
    end

    // Purpose: merge the message into the base view and pick capture halves
    always_comb begin
        rpt_next = base;
        cap_en   = 2'b00;
        if (msg_valid) begin
            case (sev)
                SEV_COR: begin
                    if (base.cor) rpt_next.mcor = 1'b1;
                    else          cap_en[0]     = 1'b1;
                    rpt_next.cor = 1'b1;
                end
                SEV_NF, SEV_FAT: begin
                    if (sev == SEV_FAT) begin
                        rpt_next.fat = 1'b1;
                        if (!base.unc) rpt_next.ffat = 1'b1;
                    end else begin
                        rpt_next.nf = 1'b1;
                    end
                    if (base.unc) rpt_next.munc = 1'b1;
                    else          cap_en[1]     = 1'b1;
                    rpt_next.unc = 1'b1;
                end
                default: begin
                    rpt_next = base;
                end
            endcase
        end
    end

endmodule

// File: rtl/aerc_src_log.sv
// Module: two source-identifier lanes that load on their capture enables and
// otherwise hold. Lane 0 forms the low half and lane 1 the high half.
// Assumes: capture enables come from aerc_msg_update; reset clears both lanes.
module aerc_src_log #(
    parameter int SRC_W = 16,
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       cap_en,
    input  logic [SRC_W-1:0]       src_in,
    output logic [LANES*SRC_W-1:0] src_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SRC_W-1:0] lane_q;

        // Purpose: hold the identifier of the first reporter of this class
        always_ff @(posedge clk) begin
            if (!rst_n)         lane_q <= '0;
            else if (cap_en[g]) lane_q <= src_in;
        end

        assign src_out[g*SRC_W +: SRC_W] = lane_q;
    end

endmodule

// File: rtl/aerc_irq_gen.sv
// Module: interrupt generation. Emits a one-cycle pulse when the enabled
// condition rises while message interrupts are on, and drives a level output
// equal to the condition while they are off.
// Assumes: the "next" inputs are the values the registers take at this edge.
module aerc_irq_gen
    import aerc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msi_en,
    input  rpt_t rpt_cur,
    input  rpt_t rpt_next,
    input  cmd_t cmd_cur,
    input  cmd_t cmd_next,
    output logic msi_pulse,
    output logic intx_out
);

    logic cond_now;
    logic cond_after;
    logic pulse_q;

    assign cond_now   = irq_cond(rpt_cur, cmd_cur);
    assign cond_after = irq_cond(rpt_next, cmd_next);

    // Purpose: register a pulse on a false-to-true change of the condition
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= msi_en & ~cond_now & cond_after;
    end

    assign msi_pulse = pulse_q;
    assign intx_out  = ~msi_en & cond_now;

endmodule

// File: rtl/aer_root_collector.sv
// Module: root port error status collector (top). Holds the reporting flags,
// the command enables and the interrupt message number, and joins the update,
// source logging and interrupt submodules.
// Assumes: one message per cycle at most; software writes arrive as strobes.
module aer_root_collector
    import aerc_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int VEC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic [1:0]         msg_sev,
    input  logic [SRC_W-1:0]   msg_src,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_wdata,
    input  logic               msi_en,
    input  logic               sts_w1c,
    input  logic [STS_W-1:0]   sts_wdata,
    input  logic               vec_load,
    input  logic [VEC_W-1:0]   vec_num,
    output logic [STS_W-1:0]   root_status,
    output logic [2*SRC_W-1:0] err_source,
    output logic [CMD_W-1:0]   root_cmd,
    output logic               msi_pulse,
    output logic               intx_out
);

    localparam int PAD_W = STS_W - VEC_W - REPORT_W;

    rpt_t             rpt_q;
    rpt_t             rpt_d;
    cmd_t             cmd_q;
    cmd_t             cmd_d;
    logic [VEC_W-1:0] vec_q;
    logic [1:0]       cap_en;
    logic             unused_wbits;

    assign unused_wbits = ^sts_wdata[STS_W-1:REPORT_W];

    aerc_msg_update u_update (
        .rpt_cur   (rpt_q),
        .clr_en    (sts_w1c),
        .clr_mask  (rpt_t'(sts_wdata[REPORT_W-1:0])),
        .msg_valid (msg_valid),
        .msg_sev   (msg_sev),
        .rpt_next  (rpt_d),
        .cap_en    (cap_en)
    );

    aerc_src_log #(.SRC_W(SRC_W), .LANES(2)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .src_in  (msg_src),
        .src_out (err_source)
    );

    // Purpose: next command value from the software write strobe
    always_comb begin
        cmd_d = cmd_q;
        if (cmd_wr) cmd_d = cmd_t'(cmd_wdata);
    end

    aerc_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_en    (msi_en),
        .rpt_cur   (rpt_q),
        .rpt_next  (rpt_d),
        .cmd_cur   (cmd_q),
        .cmd_next  (cmd_d),
        .msi_pulse (msi_pulse),
        .intx_out  (intx_out)
    );

    // Purpose: state registers for flags, enables and message number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_q <= '0;
            cmd_q <= '0;
            vec_q <= '0;
        end else begin
            rpt_q <= rpt_d;
            cmd_q <= cmd_d;
            if (vec_load) vec_q <= vec_num;
        end
    end

    assign root_status = {vec_q, {PAD_W{1'b0}}, rpt_q};
    assign root_cmd    = cmd_q;

endmodule

// File: rtl/aer_root_collector_chk.sv
// Checker: temporal properties of the collector at its ports, bound to the top.
module aer_root_collector_chk #(
    parameter int SRC_W = 16,
    parameter int VEC_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic [1:0]         msg_sev,
    input logic               msi_en,
    input logic               sts_w1c,
    input logic [31:0]        sts_wdata,
    input logic               vec_load,
    input logic [31:0]        root_status,
    input logic [2*SRC_W-1:0] err_source,
    input logic               msi_pulse,
    input logic               intx_out
);

    // R2: a held correctable flag survives unless cleared
    a_r2_cor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (root_status[0] && !(sts_w1c && sts_wdata[0])) |=> root_status[0]);

    // R2: the correctable source stays while its flag stays
    a_r2_cor_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (root_status[0] && !(sts_w1c && sts_wdata[0])) |=> $stable(err_source[SRC_W-1:0]));

    // R5: the uncorrectable source stays while its flag stays
    a_r5_unc_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (root_status[2] && !(sts_w1c && sts_wdata[2])) |=> $stable(err_source[2*SRC_W-1:SRC_W]));

    // R4: the first-fatal flag only rises on a fatal message
    a_r4_ffat_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(root_status[4]) |-> ($past(msg_valid) && $past(msg_sev) == 2'd2));

    // R8: a pulse lasts one cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |=> !msi_pulse);

    // R10: no pulse unless message interrupts were enabled
    a_r10_pulse_needs_msi: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> $past(msi_en));

    // R10: the level output needs some received flag
    a_r10_intx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        intx_out |-> (root_status[6] || root_status[5] || root_status[0]));

    // R11: the message number only moves on a load
    a_r11_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_load |=> $stable(root_status[31:32-VEC_W]));

endmodule

bind aer_root_collector aer_root_collector_chk #(.SRC_W(SRC_W), .VEC_W(VEC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_sev     (msg_sev),
    .msi_en      (msi_en),
    .sts_w1c     (sts_w1c),
    .sts_wdata   (sts_wdata),
    .vec_load    (vec_load),
    .root_status (root_status),
    .err_source  (err_source),
    .msi_pulse   (msi_pulse),
    .intx_out    (intx_out)
);

// File: tb/aer_root_collector_tb_top.sv
module aer_root_collector_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msg_valid;
    logic [1:0]  msg_sev;
    logic [15:0] msg_src;
    logic        cmd_wr;
    logic [2:0]  cmd_wdata;
    logic        msi_en;
    logic        sts_w1c;
    logic [31:0] sts_wdata;
    logic        vec_load;
    logic [4:0]  vec_num;
    logic [31:0] root_status;
    logic [31:0] err_source;
    logic [2:0]  root_cmd;
    logic        msi_pulse;
    logic        intx_out;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    aer_root_collector dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src(msg_src), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .msi_en(msi_en),
        .sts_w1c(sts_w1c), .sts_wdata(sts_wdata), .vec_load(vec_load), .vec_num(vec_num),
        .root_status(root_status), .err_source(err_source), .root_cmd(root_cmd),
        .msi_pulse(msi_pulse), .intx_out(intx_out)
    );

    // op: 0 idle, 1 message (data[15:0] = source), 2 status clear (data = mask), 3 command write
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sev;
        logic        msi;
        logic [31:0] data;
        logic [31:0] sts;
        logic [31:0] src;
        logic        pulse;
        logic        intx;
    } row_t;

    localparam int NROWS = 18;
    localparam row_t TBL [NROWS] = '{
        '{2'd3, 2'd0, 1'b1, 32'h7,    32'h00, 32'h00000000, 1'b0, 1'b0}, // R9 enable all, nothing received
        '{2'd1, 2'd0, 1'b1, 32'h1111, 32'h01, 32'h00001111, 1'b1, 1'b0}, // R2 R8 first correctable
        '{2'd1, 2'd0, 1'b1, 32'h2222, 32'h03, 32'h00001111, 1'b0, 1'b0}, // R2 repeated correctable
        '{2'd1, 2'd1, 1'b1, 32'hAAAA, 32'h27, 32'hAAAA1111, 1'b0, 1'b0}, // R3 R8 first non-fatal
        '{2'd1, 2'd2, 1'b1, 32'hBBBB, 32'h6F, 32'hAAAA1111, 1'b0, 1'b0}, // R4 R5 fatal after non-fatal
        '{2'd2, 2'd0, 1'b1, 32'h7F,   32'h00, 32'hAAAA1111, 1'b0, 1'b0}, // R6 clear all flags
        '{2'd1, 2'd2, 1'b1, 32'hCCCC, 32'h54, 32'hCCCC1111, 1'b1, 1'b0}, // R4 first fatal
        '{2'd2, 2'd0, 1'b1, 32'h7F,   32'h00, 32'hCCCC1111, 1'b0, 1'b0}, // R6
        '{2'd3, 2'd0, 1'b1, 32'h0,    32'h00, 32'hCCCC1111, 1'b0, 1'b0}, // R9 disable all
        '{2'd1, 2'd1, 1'b1, 32'h0D0D, 32'h24, 32'h0D0D1111, 1'b0, 1'b0}, // R8 class disabled
        '{2'd3, 2'd0, 1'b1, 32'h2,    32'h24, 32'h0D0D1111, 1'b1, 1'b0}, // R9 false to true
        '{2'd3, 2'd0, 1'b1, 32'h6,    32'h24, 32'h0D0D1111, 1'b0, 1'b0}, // R9 stays true
        '{2'd0, 2'd0, 1'b0, 32'h0,    32'h24, 32'h0D0D1111, 1'b0, 1'b1}, // R10 level follows
        '{2'd2, 2'd0, 1'b0, 32'h24,   32'h00, 32'h0D0D1111, 1'b0, 1'b0}, // R6 R10 partial clear
        '{2'd1, 2'd0, 1'b0, 32'h3333, 32'h01, 32'h0D0D3333, 1'b0, 1'b0}, // R10 correctable disabled
        '{2'd1, 2'd3, 1'b0, 32'hFFFF, 32'h01, 32'h0D0D3333, 1'b0, 1'b0}, // R12 unused code
        '{2'd1, 2'd2, 1'b0, 32'h4444, 32'h55, 32'h44443333, 1'b0, 1'b1}, // R10 R4 fatal, no pulse
        '{2'd2, 2'd0, 1'b0, 32'h7F,   32'h00, 32'h44443333, 1'b0, 1'b0}  // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        msg_valid = 1'b0; msg_sev = 2'd0; msg_src = '0;
        cmd_wr = 1'b0; cmd_wdata = '0;
        sts_w1c = 1'b0; sts_wdata = '0;
        vec_load = 1'b0; vec_num = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        msi_en = 1'b0;
        do_reset();
        // R1: reset state
        check("R1 status", root_status, 32'h0);
        check("R1 source", err_source, 32'h0);
        check("R1 cmd", {29'd0, root_cmd}, 32'h0);
        check("R1 pulse/intx", {30'd0, msi_pulse, intx_out}, 32'h0);

        for (int i = 0; i < NROWS; i++) begin
            msi_en = TBL[i].msi;
            case (TBL[i].op)
                2'd1: begin msg_valid = 1'b1; msg_sev = TBL[i].sev; msg_src = TBL[i].data[15:0]; end
                2'd2: begin sts_w1c = 1'b1; sts_wdata = TBL[i].data; end
                2'd3: begin cmd_wr = 1'b1; cmd_wdata = TBL[i].data[2:0]; end
                default: ;
            endcase
            @(negedge clk);
            check($sformatf("row %0d status", i), root_status, TBL[i].sts);
            check($sformatf("row %0d source", i), err_source, TBL[i].src);
            check($sformatf("row %0d pulse", i), {31'd0, msi_pulse}, {31'd0, TBL[i].pulse});
            check($sformatf("row %0d intx", i), {31'd0, intx_out}, {31'd0, TBL[i].intx});
            idle_inputs();
        end

        // R7: clear and message in one cycle
        msi_en = 1'b0;
        msg_valid = 1'b1; msg_sev = 2'd0; msg_src = 16'h5555;
        @(negedge clk); idle_inputs();
        msg_valid = 1'b1; msg_sev = 2'd0; msg_src = 16'h6666;
        sts_w1c = 1'b1; sts_wdata = 32'h7F;
        @(negedge clk); idle_inputs();
        check("R7 status after clear+msg", root_status, 32'h01);
        check("R7 source after clear+msg", err_source, 32'h44446666);

        // R11: vector load, then an all-ones clear leaves it
        vec_load = 1'b1; vec_num = 5'h15;
        @(negedge clk); idle_inputs();
        check("R11 vector loaded", root_status, {5'h15, 27'h01});
        sts_w1c = 1'b1; sts_wdata = 32'hFFFF_FFFF;
        @(negedge clk); idle_inputs();
        check("R11 vector kept", root_status, {5'h15, 27'h0});
        check("R6 source kept", err_source, 32'h44446666);

        // R1: after reset, command is zero so a message raises no pulse
        do_reset();
        check("R1 cmd after reset", {29'd0, root_cmd}, 32'h0);
        msi_en = 1'b1;
        msg_valid = 1'b1; msg_sev = 2'd2; msg_src = 16'h7777;
        @(negedge clk); idle_inputs();
        check("R1 no pulse with cmd reset", {31'd0, msi_pulse}, 32'h0);
        check("R1 R4 status", root_status, 32'h54);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule